// File: doc/BRIEF.md
# Serial CRC Codeword Checker with Data Extraction

This block takes a systematic CRC codeword one bit per accepted cycle. The codeword has M data bits followed by R check bits, and it arrives most significant bit first. The block divides the whole word, modulo 2, by the same generator the sender used. No zero bits are appended before the division. When the last bit arrives, the block reports three things: the remainder (the syndrome), a pass flag that is set only when the remainder is zero, and the M data bits with the check bits removed. Check and strip happen in the same pass, so no second walk over the word is needed.

A word begins with a `start` pulse. Its bits are then offered with `in_valid`, and the final bit is marked with `in_last`. The results appear together with a one-cycle `done` pulse. They stay unchanged until the next word completes. A non-zero syndrome is kept on the outputs because different error patterns produce different remainders, and that value is useful for diagnosis.

Top module: `crc_codeword_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done`, `crc_ok`, `syndrome` and `data_out` are all cleared to zero.
- R2: `syndrome` equals the remainder of the whole received word (first bit = highest power) divided modulo 2 by the generator. The generator is x^R plus the terms set in parameter `POLY`, where bit k of `POLY` is the coefficient of x^k. The default `POLY = 3'b011` gives generator 1011.
- R3: `crc_ok` is 1 when the syndrome of the finished word is zero, and 0 otherwise.
- R4: `data_out` holds the first M accepted bits of the word. The first bit is in `data_out[M-1]`. The last R bits of a word of M+R bits never reach `data_out`.
- R5: `done` is high for exactly one cycle, in the cycle right after the clock edge that accepts the bit with `in_last` high.
- R6: `done`, `crc_ok`, `syndrome` and `data_out` change only at a word's completion. Bits offered outside a word (before `start`, or after the last bit) are ignored.
- R7: `start` discards any word in progress. The next word's result does not depend on earlier bits.
- R8: A bit is taken only in a cycle where `in_valid` is high. Idle cycles inside a word do not change the result.
- R9: With the default generator 1011, codeword 1100010 gives syndrome 000, `crc_ok` = 1 and data 1100. Flipping any single one of its seven bits gives `crc_ok` = 0.
- R10: In a cycle where `start` and `in_valid` are both high, `start` takes effect and that bit is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a new word and clears the division state |
| in_valid | input | 1 | `in_bit` carries a codeword bit this cycle |
| in_bit | input | 1 | Serial codeword bit, most significant first |
| in_last | input | 1 | Marks the final bit of the word |
| done | output | 1 | One-cycle pulse when results are updated |
| crc_ok | output | 1 | Finished word had a zero remainder |
| syndrome | output | R | Remainder of the finished word |
| data_out | output | M | Data bits of the finished word, check bits removed |

## Verification
The remainder register and the data shift register are internal. A wrong value in either one shows up only at the next `done`, as a bad `syndrome`, `crc_ok` or `data_out`. The bench therefore checks all four outputs on every completed word, including words with in-word gaps, restarts and stray bits outside a word. A fault in the word-tracking state that drops or adds a bit shows up as a missing `done`, an extra `done`, or a shifted data field one cycle after the last bit.

// File: rtl/crc_chk_pkg.sv
// Shared types for the CRC codeword checker.
// Assumes: a single word is in flight at a time.
package crc_chk_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } chk_state_e;

endpackage

// File: rtl/crc_rem_div.sv
// Serial modulo-2 divider. Each accepted bit is shifted into the
// remainder register, and the generator's low terms are subtracted
// whenever the bit leaving the top is set.
// Assumes: R >= 2; the generator's x^R term is implicit.
module crc_rem_div #(
    parameter int            R    = 3,
    parameter logic [R-1:0]  POLY = 3'b011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [R-1:0] rem_q,
    output logic [R-1:0] rem_nxt
);

    logic fb;

    // Feedback is the coefficient that leaves the register.
    always_comb fb = rem_q[R-1];

    // Per-bit next remainder: shifted value XOR the gated generator tap.
    for (genvar k = 0; k < R; k++) begin : g_tap
        if (k == 0) begin : g_lsb
            always_comb rem_nxt[k] = bit_in ^ (fb & POLY[k]);
        end else begin : g_upper
            always_comb rem_nxt[k] = rem_q[k-1] ^ (fb & POLY[k]);
        end
    end

    // Remainder register: cleared at word start, advanced on each bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rem_q <= '0;
        end else if (shift_en) begin
            rem_q <= rem_nxt;
        end
    end

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rem_q == '0));

    p_hold_no_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !shift_en) |=> $stable(rem_q));

endmodule

// File: rtl/crc_data_capture.sv
// Keeps the first M accepted bits of a word in a shift register.
// Later bits are counted out and do not move the register.
// Assumes: M >= 1; clear arrives before the first bit of a word.
module crc_data_capture #(
    parameter int M = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [M-1:0] data_q,
    output logic [M-1:0] data_nxt
);

    localparam int CNT_W = $clog2(M + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(M);

    logic [CNT_W-1:0] cnt_q;
    logic             room;
    logic [M-1:0]     shifted;

    // Still inside the data field of the word.
    always_comb room = (cnt_q < FULL);

    // Data register contents with one more bit shifted in.
    if (M == 1) begin : g_one
        always_comb shifted = bit_in;
    end else begin : g_many
        always_comb shifted = {data_q[M-2:0], bit_in};
    end

    // Next data value, seen by the top when the last bit lands in this cycle.
    always_comb data_nxt = (shift_en && room) ? shifted : data_q;

    // Bit counter that saturates at M.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (shift_en && room) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Data shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            data_q <= '0;
        end else begin
            data_q <= data_nxt;
        end
    end

    p_no_capture_past_m_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !room) |=> $stable(data_q));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

endmodule

// File: rtl/crc_codeword_checker.sv
// CRC codeword checker with data extraction. It receives M+R bits
// serially, divides the whole word by the generator, and on the last
// bit registers the remainder, a zero-remainder flag and the first
// M bits.
// Assumes: in_last marks the final bit; start precedes every word.
module crc_codeword_checker
    import crc_chk_pkg::*;
#(
    parameter int           M    = 4,
    parameter int           R    = 3,
    parameter logic [R-1:0] POLY = 3'b011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         in_valid,
    input  logic         in_bit,
    input  logic         in_last,
    output logic         done,
    output logic         crc_ok,
    output logic [R-1:0] syndrome,
    output logic [M-1:0] data_out
);

    chk_state_e   state_q;
    logic         accept;
    logic         finish;
    logic [R-1:0] rem_q;
    logic [R-1:0] rem_nxt;
    logic [M-1:0] data_q;
    logic [M-1:0] data_nxt;

    // A bit counts only inside a word and never alongside start.
    always_comb accept = (state_q == ST_BUSY) && in_valid && !start;
    always_comb finish = accept && in_last;

    // Word tracking: busy from start until the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (start) begin
            state_q <= ST_BUSY;
        end else if (finish) begin
            state_q <= ST_IDLE;
        end
    end

    crc_rem_div #(.R(R), .POLY(POLY)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .shift_en (accept),
        .bit_in   (in_bit),
        .rem_q    (rem_q),
        .rem_nxt  (rem_nxt)
    );

    crc_data_capture #(.M(M)) i_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .shift_en (accept),
        .bit_in   (in_bit),
        .data_q   (data_q),
        .data_nxt (data_nxt)
    );

    // Result registers: loaded once per word, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            crc_ok   <= 1'b0;
            syndrome <= '0;
            data_out <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                crc_ok   <= (rem_nxt == '0);
                syndrome <= rem_nxt;
                data_out <= data_nxt;
            end
        end
    end

    p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_results_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(syndrome) && $stable(crc_ok) && $stable(data_out)));

    p_ok_agrees_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (crc_ok == (syndrome == '0)));

    p_start_drops_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && rem_q == '0));

endmodule

// File: tb/test_crc_codeword_checker.sv
module test_crc_codeword_checker;

    localparam int           M    = 4;
    localparam int           R    = 3;
    localparam int           N    = M + R;
    localparam logic [R-1:0] POLY = 3'b011;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_bit = 1'b0;
    logic         in_last = 1'b0;
    logic         done;
    logic         crc_ok;
    logic [R-1:0] syndrome;
    logic [M-1:0] data_out;

    int checks = 0;
    int fails  = 0;
    int gap_pct = 0;

    always #2.5 clk = ~clk;

    crc_codeword_checker #(.M(M), .R(R), .POLY(POLY)) i_crc_codeword_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_bit(in_bit), .in_last(in_last), .done(done), .crc_ok(crc_ok),
        .syndrome(syndrome), .data_out(data_out)
    );

    // Long division with the full generator aligned under each leading one.
    function automatic logic [R-1:0] ref_rem(input logic [N-1:0] w);
        logic [N-1:0] work = w;
        logic [N-1:0] gen = N'({1'b1, POLY});
        for (int i = N - 1; i >= R; i--) begin
            if (work[i]) work = work ^ (gen << (i - R));
        end
        return work[R-1:0];
    endfunction

    function automatic logic [N-1:0] make_cw(input logic [M-1:0] d);
        logic [N-1:0] base = {d, {R{1'b0}}};
        return base | N'(ref_rem(base));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bits are driven on negedges. The last bit is sampled at the next
    // posedge, so done is checked at the negedge after it.
    task automatic send_bits(input logic [N-1:0] w);
        for (int i = N - 1; i >= 0; i--) begin
            while (($urandom % 100) < gap_pct) begin
                in_valid = 1'b0;
                in_last  = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_bit   = w[i];
            in_last  = (i == 0);
            @(negedge clk);
            if (i != 0) chk("R5 early done", done, 1'b0);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_word(input logic [N-1:0] w, input string tag);
        logic [R-1:0] er = ref_rem(w);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        send_bits(w);
        chk({"R5 done ", tag}, done, 1'b1);
        chk({"R2 syndrome ", tag}, syndrome, er);
        chk({"R3 crc_ok ", tag}, crc_ok, (er == '0));
        chk({"R4 data ", tag}, data_out, w[N-1:R]);
        @(negedge clk);
        chk({"R5 pulse ", tag}, done, 1'b0);
    endtask

    initial begin
        int dummy = $urandom(32'd1234);
        logic [R-1:0] s_hold;
        logic [M-1:0] d_hold;
        logic         o_hold;
        repeat (3) @(negedge clk);
        chk("R1 done", done, 1'b0);
        chk("R1 crc_ok", crc_ok, 1'b0);
        chk("R1 syndrome", syndrome, 0);
        chk("R1 data", data_out, 0);
        rst_n = 1'b1;

        // R9: directed example and every single-bit flip of it.
        chk("R9 ref", make_cw(4'b1100), 7'b1100010);
        run_word(7'b1100010, "R9 clean");
        chk("R9 clean ok", crc_ok, 1'b1);
        for (int b = 0; b < N; b++) begin
            run_word(7'b1100010 ^ (7'b1 << b), "R9 flip");
            chk("R9 flip ok", crc_ok, 1'b0);
        end

        // R6: stray bits while idle, including a last flag, are ignored.
        s_hold = syndrome; d_hold = data_out; o_hold = crc_ok;
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1; in_bit = 1'b1; in_last = (i == 4);
            @(negedge clk);
            chk("R6 idle done", done, 1'b0);
        end
        in_valid = 1'b0; in_last = 1'b0;
        chk("R6 hold syndrome", syndrome, s_hold);
        chk("R6 hold data", data_out, d_hold);
        chk("R6 hold ok", crc_ok, o_hold);
        run_word(make_cw(4'b1011), "R6 after idle");

        // R10: bit presented with start is dropped.
        @(negedge clk);
        start = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        send_bits(make_cw(4'b0110));
        chk("R10 done", done, 1'b1);
        chk("R10 ok", crc_ok, 1'b1);
        chk("R10 data", data_out, 4'b0110);

        // R7: abandon a half word, restart, and expect a clean result.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1; in_bit = 1'b1; in_last = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b0;
        run_word(make_cw(4'b0011), "R7 restart");
        chk("R7 ok", crc_ok, 1'b1);

        // R8 and R2 to R4: random words with random gaps and error masks.
        for (int n = 0; n < 60; n++) begin
            logic [M-1:0] d = M'($urandom);
            logic [N-1:0] e = (($urandom % 3) == 0) ? N'($urandom) : '0;
            gap_pct = (n % 2) ? 40 : 0;
            run_word(make_cw(d) ^ e, "R8 random");
        end
        gap_pct = 0;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule